// File: doc/BRIEF.md
# Priority Round-Robin Slave Arbiter

This block sits in front of a single slave port of a multi-layer bus matrix, with one copy per slave. Every master connected to that slave drives a request line, and each master has a programmable priority value. In every cycle the arbiter looks only at the masters that are requesting and finds the smallest priority value among them. It then rotates fairly among the masters that share that value. The one-hot grant is combinational. A master keeps its request high until the cycle in which it sees its grant bit.

Each grant writes the identity of the granted master into a short send queue. An entry becomes visible to the slave a fixed number of cycles after it was written. The slave removes the head entry by raising its ready input while the entry is presented. Arbitration stops while the queue is full.

Round-robin state is held separately for each priority level. A burst of traffic at one level therefore does not change the rotation order at another level.

Top module: `pra_slave_arb`

## Requirements
- R1: `gnt_o` has at most one bit set, and a bit is set only for a master whose request bit is high in the same cycle.
- R2: When requesters have different priority values, the grant goes to a requester with the numerically smallest 3-bit value (0 is the most urgent).
- R3: Among requesters that share the winning value, the grant goes to the first one found when scanning upward from that level's pointer, wrapping from master NM-1 to master 0. After a grant, that level's pointer moves to the granted index plus one, modulo NM.
- R4: Every priority level has its own pointer, and all pointers start at 0 after reset. A grant at one level leaves the rotation order of every other level unchanged.
- R5: A master whose request is not granted keeps requesting. In every cycle with at least one request and a queue that is not full, exactly one grant is issued, so every held request is eventually served.
- R6: Each grant writes the master's index into a send queue of QD entries (4 by default). No grant is issued in a cycle that begins with the queue full.
- R7: An entry written by a grant in cycle c is presented at the head (`slv_valid_o` high) no earlier than cycle c+1+FWD_DLY. If it is already at the head, it is presented exactly in that cycle.
- R8: Entries reach the slave in grant order. `slv_valid_o` and `slv_id_o` hold steady until the slave raises `slv_ready_i`, and the entry is removed at the end of that cycle.
- R9: After reset there is no grant, the queue is empty and `slv_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NM | Request line for each master |
| prio_i | input | NM*PW | Priority value per master; master i uses bits [i*PW +: PW] |
| gnt_o | output | NM | One-hot grant, combinational |
| slv_valid_o | output | 1 | Head entry of the send queue is ready for the slave |
| slv_id_o | output | IW | Index of the master in the head entry |
| slv_ready_i | input | 1 | Slave accepts the head entry |

## Verification
The bench builds the block with eight masters, 3-bit priorities, a four-entry queue and a forwarding delay of 2. With a delay that short, a ready slave keeps at most three entries in flight, so a fully ready slave never fills the queue. The queue-full stall is reached only by holding ready low. The bench also lets two masters at one level alternate while another level takes its own grants, which shows that the per-level pointers are independent. A seeded pseudo-random phase mixes priorities, request bursts and slave stalls, and is checked against a behavioural model on every cycle.

// File: rtl/pra_pkg.sv
package pra_pkg;

  // Fold an index that has stepped at most one lap past n back into range.
  function automatic int rr_wrap(input int v, input int n);
    return (v >= n) ? v - n : v;
  endfunction

  // Index that follows i in a ring of n slots.
  function automatic int next_slot(input int i, input int n);
    return rr_wrap(i + 1, n);
  endfunction

  // Saturating age step toward a ceiling.
  function automatic int age_step(input int a, input int ceil_v);
    return (a >= ceil_v) ? ceil_v : a + 1;
  endfunction

endpackage

// File: rtl/pra_level_min.sv
module pra_level_min #(
  parameter int NM = 8,
  parameter int PW = 3
) (
  input  logic [NM-1:0]    req,
  input  logic [NM*PW-1:0] prio,
  output logic             any_req,
  output logic [PW-1:0]    win_lvl,
  output logic [NM-1:0]    cand
);

  logic [PW-1:0] best;
  logic          seen;

  always_comb begin
    best = '1;
    seen = 1'b0;
    for (int i = 0; i < NM; i++) begin
      if (req[i] && (!seen || prio[i*PW +: PW] < best)) begin
        best = prio[i*PW +: PW];
        seen = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NM; i++)
      cand[i] = req[i] && (prio[i*PW +: PW] == best);
  end

  assign any_req = seen;
  assign win_lvl = best;

endmodule

// File: rtl/pra_rr_pick.sv
module pra_rr_pick #(
  parameter int NM = 8,
  parameter int PW = 3,
  parameter int IW = $clog2(NM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] cand,
  input  logic [PW-1:0] lvl,
  input  logic          take,
  output logic [NM-1:0] pick_oh,
  output logic [IW-1:0] pick_idx
);

  localparam int LVLS = 1 << PW;

  logic [IW-1:0] ptr_all [LVLS];
  logic [IW-1:0] ptr_cur;
  logic          found;

  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    logic [IW-1:0] ptr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ptr_q <= '0;
      else if (take && (lvl == PW'(g)))
        ptr_q <= IW'(pra_pkg::next_slot(int'(pick_idx), NM));
    end
    assign ptr_all[g] = ptr_q;
  end

  assign ptr_cur = ptr_all[lvl];

  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    found    = 1'b0;
    for (int k = 0; k < NM; k++) begin
      int idx;
      idx = pra_pkg::rr_wrap(int'(ptr_cur) + k, NM);
      if (!found && cand[idx]) begin
        found        = 1'b1;
        pick_oh[idx] = 1'b1;
        pick_idx     = IW'(idx);
      end
    end
  end

endmodule

// File: rtl/pra_send_q.sv
module pra_send_q #(
  parameter int         QD      = 4,
  parameter int         IW      = 3,
  parameter logic [3:0] FWD_DLY = 4'd3,
  parameter int         CW      = $clog2(QD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_id,
  input  logic          pop_ok,
  output logic          full,
  output logic          head_vld,
  output logic [IW-1:0] head_id,
  output logic [CW-1:0] cnt
);

  localparam int AW = (QD > 1) ? $clog2(QD) : 1;

  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] id_all  [QD];
  logic [3:0]    age_all [QD];
  logic          pop;

  for (genvar s = 0; s < QD; s++) begin : g_slot
    logic [IW-1:0] id_q;
    logic [3:0]    age_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q  <= '0;
        age_q <= '0;
      end else if (push && (wr_q == AW'(s))) begin
        id_q  <= push_id;
        age_q <= '0;
      end else begin
        age_q <= 4'(pra_pkg::age_step(int'(age_q), int'(FWD_DLY)));
      end
    end
    assign id_all[s]  = id_q;
    assign age_all[s] = age_q;
  end

  assign full     = (cnt_q == CW'(QD));
  assign head_vld = (cnt_q != '0) && (age_all[rd_q] == FWD_DLY);
  assign head_id  = id_all[rd_q];
  assign pop      = head_vld && pop_ok;
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= AW'(pra_pkg::next_slot(int'(wr_q), QD));
      if (pop)  rd_q <= AW'(pra_pkg::next_slot(int'(rd_q), QD));
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

endmodule

// File: rtl/pra_slave_arb.sv
module pra_slave_arb #(
  parameter int         NM      = 8,
  parameter int         PW      = 3,
  parameter int         QD      = 4,
  parameter logic [3:0] FWD_DLY = 4'd3,
  localparam int        IW      = $clog2(NM),
  localparam int        CW      = $clog2(QD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    req_i,
  input  logic [NM*PW-1:0] prio_i,
  output logic [NM-1:0]    gnt_o,
  output logic             slv_valid_o,
  output logic [IW-1:0]    slv_id_o,
  input  logic             slv_ready_i
);

  // Named internal events, observed by the bound checker.
  logic          any_req;
  logic [PW-1:0] win_lvl;
  logic [NM-1:0] cand;
  logic [NM-1:0] pick_oh;
  logic [IW-1:0] pick_idx;
  logic          q_full;
  logic [CW-1:0] q_cnt;
  logic          arb_fire;

  pra_level_min #(.NM(NM), .PW(PW)) u_min (
    .req     (req_i),
    .prio    (prio_i),
    .any_req (any_req),
    .win_lvl (win_lvl),
    .cand    (cand)
  );

  assign arb_fire = any_req && !q_full;

  pra_rr_pick #(.NM(NM), .PW(PW), .IW(IW)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand     (cand),
    .lvl      (win_lvl),
    .take     (arb_fire),
    .pick_oh  (pick_oh),
    .pick_idx (pick_idx)
  );

  pra_send_q #(.QD(QD), .IW(IW), .FWD_DLY(FWD_DLY), .CW(CW)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (arb_fire),
    .push_id  (pick_idx),
    .pop_ok   (slv_ready_i),
    .full     (q_full),
    .head_vld (slv_valid_o),
    .head_id  (slv_id_o),
    .cnt      (q_cnt)
  );

  assign gnt_o = arb_fire ? pick_oh : '0;

endmodule

// File: rtl/pra_slave_arb_chk.sv
module pra_slave_arb_chk #(
  parameter int NM = 8,
  parameter int QD = 4,
  parameter int IW = 3,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] req_i,
  input logic [NM-1:0] gnt_o,
  input logic          q_full,
  input logic [CW-1:0] q_cnt,
  input logic          slv_valid_o,
  input logic [IW-1:0] slv_id_o,
  input logic          slv_ready_i
);

  assert_gnt_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  assert_gnt_to_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0);

  assert_progress_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_i) && !q_full) |-> (|gnt_o));

  assert_no_grant_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> (gnt_o == '0));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_cnt) <= QD);

  assert_head_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_valid_o && !slv_ready_i) |=> (slv_valid_o && $stable(slv_id_o)));

endmodule

bind pra_slave_arb pra_slave_arb_chk #(.NM(NM), .QD(QD), .IW(IW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .gnt_o       (gnt_o),
  .q_full      (q_full),
  .q_cnt       (q_cnt),
  .slv_valid_o (slv_valid_o),
  .slv_id_o    (slv_id_o),
  .slv_ready_i (slv_ready_i)
);

// File: tb/pra_slave_arb_bench.sv
`timescale 1ns/1ps
module pra_slave_arb_bench;

  localparam int         NM  = 8;
  localparam int         PW  = 3;
  localparam int         QD  = 4;
  localparam int         DLY = 2;
  localparam int         IW  = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NM-1:0]    req_i = '0;
  logic [NM*PW-1:0] prio_i = '0;
  logic [NM-1:0]    gnt_o;
  logic             slv_valid_o;
  logic [IW-1:0]    slv_id_o;
  logic             slv_ready_i = 1'b0;

  always #5 clk = ~clk;

  pra_slave_arb #(.NM(NM), .PW(PW), .QD(QD), .FWD_DLY(4'(DLY))) u_pra_slave_arb (
    .clk (clk), .rst_n (rst_n), .req_i (req_i), .prio_i (prio_i),
    .gnt_o (gnt_o), .slv_valid_o (slv_valid_o), .slv_id_o (slv_id_o),
    .slv_ready_i (slv_ready_i)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state.
  int       ptr_m [8];
  int       mq_id [$];
  int       mq_age[$];
  bit [7:0] pend, persist, inject, prev_gnt;
  int       prio_m[8];
  bit       ready;
  int       last_gidx;
  int       last_lvl;
  string    phase_tag;
  int unsigned lcg = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rnd(input int n);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) % n);
  endfunction

  task automatic step();
    bit [7:0] exp_g;
    int minp, gidx;
    bit full, ev;
    int eid;
    @(negedge clk);
    pend   = (pend & ~prev_gnt) | persist | inject;
    inject = '0;
    req_i  = pend;
    for (int i = 0; i < NM; i++) prio_i[i*PW +: PW] = 3'(prio_m[i]);
    slv_ready_i = ready;
    #1;
    full  = (mq_id.size() == QD);
    exp_g = '0;
    gidx  = -1;
    minp  = 8;
    if (!full && pend != 0) begin
      for (int i = 0; i < NM; i++) if (pend[i] && prio_m[i] < minp) minp = prio_m[i];
      for (int k = 0; k < NM; k++) begin
        int idx;
        idx = (ptr_m[minp] + k) % NM;
        if (gidx < 0 && pend[idx] && prio_m[idx] == minp) gidx = idx;
      end
      exp_g[gidx] = 1'b1;
    end
    ev  = (mq_id.size() > 0) && (mq_age[0] >= DLY);
    eid = ev ? mq_id[0] : 0;
    chk(gnt_o == exp_g, phase_tag, int'(gnt_o), int'(exp_g));
    chk($onehot0(gnt_o) && ((gnt_o & ~pend) == 0), "R1", int'(gnt_o), int'(exp_g));
    if (full) chk(gnt_o == 0, "R6", int'(gnt_o), 0);
    chk(slv_valid_o == ev, "R7", int'(slv_valid_o), int'(ev));
    if (ev) chk(int'(slv_id_o) == eid, "R8", int'(slv_id_o), eid);
    // advance model to the coming edge
    if (ev && ready) begin
      void'(mq_id.pop_front());
      void'(mq_age.pop_front());
    end
    foreach (mq_age[j]) if (mq_age[j] < DLY) mq_age[j]++;
    if (gidx >= 0) begin
      mq_id.push_back(gidx);
      mq_age.push_back(0);
      ptr_m[minp] = (gidx + 1) % NM;
    end
    prev_gnt  = exp_g;
    last_gidx = gidx;
    last_lvl  = minp;
  endtask

  task automatic drain(input int n);
    persist = '0;
    ready   = 1'b1;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    int seq[5];
    int exp_seq[5];
    int grants, prev5;
    bit alt_ok;
    for (int i = 0; i < 8; i++) begin ptr_m[i] = 0; prio_m[i] = 7; end
    pend = '0; persist = '0; inject = '0; prev_gnt = '0; ready = 1'b1;
    phase_tag = "R9";
    repeat (3) @(posedge clk);
    #2;
    chk(gnt_o == 0 && slv_valid_o == 0, "R9", int'({gnt_o, slv_valid_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step();

    // R2 and R3: one urgent master, then two equal masters alternate.
    phase_tag = "R3";
    prio_m[0] = 1; prio_m[1] = 3; prio_m[2] = 3;
    inject  = 8'b0000_0001;
    persist = 8'b0000_0110;
    exp_seq = '{0, 1, 2, 1, 2};
    for (int i = 0; i < 5; i++) begin step(); seq[i] = last_gidx; end
    chk(seq[0] == 0, "R2", seq[0], 0);
    for (int i = 1; i < 5; i++) chk(seq[i] == exp_seq[i], "R3", seq[i], exp_seq[i]);
    drain(12);

    // R4: level-5 rotation undisturbed by level-2 traffic.
    phase_tag = "R4";
    for (int i = 0; i < 8; i++) prio_m[i] = 7;
    prio_m[3] = 5; prio_m[6] = 5; prio_m[4] = 2; prio_m[7] = 2;
    persist = 8'b0100_1000;
    prev5 = -1; alt_ok = 1;
    for (int i = 0; i < 24; i++) begin
      if (i % 5 == 1) inject = 8'b0001_0000;
      if (i % 7 == 3) inject = 8'b1001_0000;
      step();
      if (last_lvl == 5 && last_gidx >= 0) begin
        if (last_gidx == prev5) alt_ok = 0;
        prev5 = last_gidx;
      end
    end
    chk(alt_ok, "R4", int'(alt_ok), 1);
    drain(15);

    // R6 and R8: stalled slave fills the queue, then ordered drain.
    phase_tag = "R6";
    for (int i = 0; i < 8; i++) prio_m[i] = 4;
    ready = 1'b0;
    persist = 8'hFF;
    grants = 0;
    for (int i = 0; i < 10; i++) begin step(); if (last_gidx >= 0) grants++; end
    chk(grants == QD, "R6", grants, QD);
    phase_tag = "R8";
    drain(40);

    // R5: pseudo-random mix.
    phase_tag = "R5";
    for (int c = 0; c < 200; c++) begin
      if (c % 16 == 0) for (int i = 0; i < 8; i++) prio_m[i] = rnd(8);
      inject = 8'(rnd(256)) & 8'(rnd(256));
      ready  = (rnd(4) != 0);
      step();
    end
    drain(60);
    chk(pend == 0, "R5", int'(pend), 0);

    // R7: forwarding delay of a single entry.
    phase_tag = "R7";
    inject = 8'b0010_0000;
    step();
    chk(last_gidx == 5, "R7", last_gidx, 5);
    for (int i = 0; i < DLY; i++) begin
      step();
      chk(slv_valid_o == 1'b0, "R7", int'(slv_valid_o), 0);
    end
    step();
    chk(slv_valid_o == 1'b1 && slv_id_o == 3'd5, "R7", int'(slv_id_o), 5);
    drain(5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule